// File: doc/BRIEF.md
# H.264 Block Coefficient Quantizer

This block takes one 4x4 block of signed 16-bit transform coefficients and turns it into sixteen quantized levels in one pass. It uses a quantization parameter from 0 to 51. Sixteen identical lanes work side by side, one per coefficient position.

Each lane:
- takes the magnitude of its coefficient,
- scales it by a factor chosen from the lane's position class and the parameter,
- adds a rounding offset,
- shifts right by a parameter-derived amount,
- gives the result the input's sign again.

A luma-DC select makes every lane use the even/even factor and shift one place further. An intra select picks the larger of the two rounding offsets.

A caller presents the block together with a one-cycle `start` pulse. The quantized block appears four clock edges later, marked by a one-cycle `done`. A new block may be started on every cycle.

Top module: `coef_quantizer`

## Requirements
- R1: While `rst` is high, and after it is released until the first result, `done` is 0 and every output coefficient is 0.
- R2: A block sampled with `start` high at clock edge k is presented on `coef_out`, with `done` high, after edge k+4. `done` stays high for that one cycle only. The outputs keep their value until the next result.
- R3: The shift amount for a non-DC block is qs = 15 + floor(qp/6), which gives 15 to 23 over qp 0..51.
- R4: Coefficient p sits at bits p*16+15:p*16 of both data ports and has row p/4 and column p%4. Lanes with even row and even column use factors 13107, 11916, 10082, 9362, 8192, 7282 for qp%6 = 0..5. Lanes with odd row and odd column use 5243, 4660, 4194, 3647, 3355, 2893. All other lanes use 8066, 7490, 6554, 5825, 5243, 4559.
- R5: For a non-DC block, |Z| = (|Y|*F + r) >> qs, where F is the factor from R4. The rounding offset r is floor(2^qs/3) when `intra` is 1 and floor(2^qs/6) when `intra` is 0.
- R6: With `dc_mode` = 1, every lane uses the even/even factor of R4, adds 2*r, and shifts by qs+1.
- R7: A negative input yields -|Z|. A non-negative input yields +|Z|. A zero input yields exactly 0.
- R8: Blocks started on consecutive cycles come out on consecutive cycles, each with its own parameters.
- R9: Full-scale inputs, -32768 and +32767, quantize without overflow at every qp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample the block on this edge |
| qp | input | 6 | Quantization parameter, 0..51 |
| dc_mode | input | 1 | Luma-DC quantization select |
| intra | input | 1 | 1: intra rounding, 0: inter rounding |
| coef_in | input | 256 | Sixteen signed 16-bit coefficients |
| coef_out | output | 256 | Sixteen signed 16-bit quantized levels |
| done | output | 1 | Result valid pulse |

## Verification
The table-driven blocks use linear ramps with alternating signs, spread over qp from 0 to 51. Each ramp therefore reaches all three position classes in one block, and both signs under a single parameter.

Table rows differ in rounding select and DC mode, so an offset or shift that is one step off shows up in at least one lane. An all-zero block separates a clean zero from a negated zero. Full-scale blocks at qp 0 expose any product or sum that is too narrow. Two starts on adjacent cycles, using different qp, show whether parameters are carried along with their own block through the pipeline.

// File: rtl/qz_pkg.sv
package qz_pkg;
    localparam int CW     = 16;          // coefficient width
    localparam int MW     = 14;          // factor width
    localparam int PW     = CW + MW;     // product width
    localparam int SW     = 32;          // pre-shift sum width
    localparam int QW     = 6;           // qp width
    localparam int SHW    = 5;           // shift amount width
    localparam int DIM    = 4;
    localparam int NCOEF  = DIM * DIM;
    localparam int STAGES = 4;

    typedef enum logic [1:0] {CLS_EE, CLS_OO, CLS_MIX} pos_cls_e;

    typedef struct packed {
        logic [CW-1:0]  mag;
        logic           neg;
        logic [MW-1:0]  mf;
        logic [SW-1:0]  off;
        logic [SHW-1:0] sh;
    } lk_st_t;

    typedef struct packed {
        logic [PW-1:0]  prod;
        logic           neg;
        logic [SW-1:0]  off;
        logic [SHW-1:0] sh;
    } mul_st_t;

    typedef struct packed {
        logic [SW-1:0]  sum;
        logic           neg;
        logic [SHW-1:0] sh;
    } add_st_t;

    function automatic pos_cls_e pos_class(input int row, input int col);
        if ((row % 2 == 0) && (col % 2 == 0)) return CLS_EE;
        if ((row % 2 == 1) && (col % 2 == 1)) return CLS_OO;
        return CLS_MIX;
    endfunction

    function automatic logic [SHW-1:0] qbits_of(input logic [QW-1:0] qp);
        logic [QW-1:0] d;
        d = qp / QW'(6);
        return SHW'(15) + SHW'(d);
    endfunction

    function automatic logic [2:0] qmod_of(input logic [QW-1:0] qp);
        return 3'(qp % QW'(6));
    endfunction

    function automatic logic [SW-1:0] rnd_of(input logic [SHW-1:0] qb, input logic intra);
        logic [SW-1:0] full;
        full = SW'(1) << qb;
        return intra ? (full / SW'(3)) : (full / SW'(6));
    endfunction

    function automatic logic [MW-1:0] mf_of(input pos_cls_e cls, input logic [2:0] m);
        logic [MW-1:0] v;
        unique case (cls)
            CLS_EE: case (m)
                3'd0: v = 14'd13107; 3'd1: v = 14'd11916; 3'd2: v = 14'd10082;
                3'd3: v = 14'd9362;  3'd4: v = 14'd8192;  default: v = 14'd7282;
            endcase
            CLS_OO: case (m)
                3'd0: v = 14'd5243;  3'd1: v = 14'd4660;  3'd2: v = 14'd4194;
                3'd3: v = 14'd3647;  3'd4: v = 14'd3355;  default: v = 14'd2893;
            endcase
            default: case (m)
                3'd0: v = 14'd8066;  3'd1: v = 14'd7490;  3'd2: v = 14'd6554;
                3'd3: v = 14'd5825;  3'd4: v = 14'd5243;  default: v = 14'd4559;
            endcase
        endcase
        return v;
    endfunction
endpackage

// File: rtl/qz_ctrl.sv
module qz_ctrl
    import qz_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [STAGES-1:0] stage_ld,
    output logic              done
);
    logic [STAGES-1:0] vld;

    always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else     vld <= {vld[STAGES-2:0], start};
    end

    assign stage_ld = {vld[STAGES-2:0], start};
    assign done     = vld[STAGES-1];

    // R2
    done_has_origin_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 4));

    // R2
    start_reaches_done_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> ##4 done);
endmodule

// File: rtl/qz_pe.sv
module qz_pe
    import qz_pkg::*;
#(
    parameter int ROW = 0,
    parameter int COL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] ld,
    input  logic [QW-1:0]     qp,
    input  logic              dc_mode,
    input  logic              intra,
    input  logic [CW-1:0]     coef_in,
    output logic [CW-1:0]     coef_out
);
    localparam pos_cls_e CLS = pos_class(ROW, COL);

    lk_st_t  s1, s1_d;
    mul_st_t s2;
    add_st_t s3;
    logic [CW-1:0]  in_mag;
    logic [SHW-1:0] qb;
    logic [2:0]     qm;
    logic [SW-1:0]  rnd;
    logic [CW-1:0]  zmag;

    assign in_mag = coef_in[CW-1] ? (~coef_in + 1'b1) : coef_in;
    assign qb     = qbits_of(qp);
    assign qm     = qmod_of(qp);
    assign rnd    = rnd_of(qb, intra);

    always_comb begin
        s1_d.mag = in_mag;
        s1_d.neg = coef_in[CW-1];
        s1_d.mf  = dc_mode ? mf_of(CLS_EE, qm) : mf_of(CLS, qm);
        s1_d.off = dc_mode ? (rnd << 1) : rnd;
        s1_d.sh  = qb + SHW'(dc_mode);
    end

    assign zmag = CW'(s3.sum >> s3.sh);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
            coef_out <= '0;
        end else begin
            if (ld[0]) s1 <= s1_d;
            if (ld[1]) begin
                s2.prod <= PW'(s1.mag) * PW'(s1.mf);
                s2.neg  <= s1.neg;
                s2.off  <= s1.off;
                s2.sh   <= s1.sh;
            end
            if (ld[2]) begin
                s3.sum <= SW'(s2.prod) + s2.off;
                s3.neg <= s2.neg;
                s3.sh  <= s2.sh;
            end
            if (ld[3]) coef_out <= s3.neg ? (~zmag + 1'b1) : zmag;
        end
    end

    logic [CW-1:0] out_mag;
    assign out_mag = coef_out[CW-1] ? (~coef_out + 1'b1) : coef_out;

    // R7
    zero_in_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
        (ld[0] && coef_in == '0) |-> ##4 (coef_out == '0));

    // R7
    sign_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (ld[0] && !coef_in[CW-1]) |-> ##4 !coef_out[CW-1]);

    // R9
    no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        ld[0] |-> ##4 (out_mag <= $past(in_mag, 4)));
endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer
    import qz_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [QW-1:0]       qp,
    input  logic                dc_mode,
    input  logic                intra,
    input  logic [NCOEF*CW-1:0] coef_in,
    output logic [NCOEF*CW-1:0] coef_out,
    output logic                done
);
    logic [STAGES-1:0] stage_ld;

    qz_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stage_ld (stage_ld),
        .done     (done)
    );

    for (genvar p = 0; p < NCOEF; p++) begin : g_lane
        qz_pe #(.ROW(p / DIM), .COL(p % DIM)) u_pe (
            .clk      (clk),
            .rst      (rst),
            .ld       (stage_ld),
            .qp       (qp),
            .dc_mode  (dc_mode),
            .intra    (intra),
            .coef_in  (coef_in[p*CW +: CW]),
            .coef_out (coef_out[p*CW +: CW])
        );
    end
endmodule

// File: tb/tb_coef_quantizer.sv
`timescale 1ns/1ps
module tb_coef_quantizer;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [5:0]   qp = '0;
    logic         dc_mode = 1'b0;
    logic         intra = 1'b0;
    logic [255:0] coef_in = '0;
    logic [255:0] coef_out;
    logic         done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    coef_quantizer dut (
        .clk(clk), .rst(rst), .start(start), .qp(qp), .dc_mode(dc_mode),
        .intra(intra), .coef_in(coef_in), .coef_out(coef_out), .done(done)
    );

    localparam int NV = 8;
    localparam int V_QP   [NV] = '{0, 5, 17, 28, 51, 12, 40, 51};
    localparam int V_DC   [NV] = '{0, 0, 0, 0, 0, 1, 1, 1};
    localparam int V_INTRA[NV] = '{1, 0, 1, 0, 1, 1, 0, 0};
    localparam int V_BASE [NV] = '{100, 2000, -3000, 12345, 32767, 500, -7000, 30000};
    localparam int V_STEP [NV] = '{37, -111, 401, -900, -2048, 250, 777, -1999};

    int pat [16];
    int expa[16];
    int expb[16];

    function automatic int mf_model(int q, int p, bit dc);
        int r, c, m, cls;
        r = p / 4; c = p % 4; m = q % 6;
        cls = dc ? 0 : (((r % 2) == 0 && (c % 2) == 0) ? 0 :
                        ((r % 2) == 1 && (c % 2) == 1) ? 1 : 2);
        case (cls)
            0: case (m) 0: return 13107; 1: return 11916; 2: return 10082;
                        3: return 9362;  4: return 8192;  default: return 7282; endcase
            1: case (m) 0: return 5243;  1: return 4660;  2: return 4194;
                        3: return 3647;  4: return 3355;  default: return 2893; endcase
            default: case (m) 0: return 8066; 1: return 7490; 2: return 6554;
                        3: return 5825;  4: return 5243;  default: return 4559; endcase
        endcase
    endfunction

    function automatic int quant_model(int y, int q, bit dc, bit intr, int p);
        int qs, sh;
        longint r, off, mag, z;
        qs  = 15 + q / 6;
        r   = intr ? ((64'd1 << qs) / 3) : ((64'd1 << qs) / 6);
        off = dc ? 2 * r : r;
        sh  = dc ? qs + 1 : qs;
        mag = (y < 0) ? -y : y;
        z   = (mag * mf_model(q, p, dc) + off) >>> sh;
        return (y < 0) ? -int'(z) : int'(z);
    endfunction

    task automatic make_ramp(int base, int step);
        for (int p = 0; p < 16; p++) begin
            int v;
            v = base + step * p;
            if (p % 2 == 1) v = -v;
            if (v > 32767) v = 32767;
            if (v < -32768) v = -32768;
            pat[p] = v;
        end
    endtask

    task automatic fill_all(int v);
        for (int p = 0; p < 16; p++) pat[p] = v;
    endtask

    task automatic drive(int q, bit dc, bit intr);
        qp = 6'(q); dc_mode = dc; intra = intr; start = 1'b1;
        for (int p = 0; p < 16; p++) coef_in[p*16 +: 16] = 16'(pat[p]);
    endtask

    task automatic compute(int q, bit dc, bit intr, output int e[16]);
        for (int p = 0; p < 16; p++) e[p] = quant_model(pat[p], q, dc, intr, p);
    endtask

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_block(string tag, int e[16]);
        check({tag, " done"}, int'(done), 1);
        for (int p = 0; p < 16; p++)
            check($sformatf("%s p%0d", tag, p), int'($signed(coef_out[p*16 +: 16])), e[p]);
    endtask

    task automatic run_one(string tag, int q, bit dc, bit intr);
        compute(q, dc, intr, expa);
        @(negedge clk);
        drive(q, dc, intr);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check_block(tag, expa);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 done in reset", int'(done), 0);
        check("R1 outputs in reset", int'(coef_out == '0), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", int'(done), 0);
        check("R1 outputs after reset", int'(coef_out == '0), 1);

        // R3 R4 R5 R6 R7: table of ramp blocks
        for (int v = 0; v < NV; v++) begin
            make_ramp(V_BASE[v], V_STEP[v]);
            run_one($sformatf("R3/R4/R5/R6/R7 vec%0d", v), V_QP[v], 1'(V_DC[v]), 1'(V_INTRA[v]));
        end

        // R2: done is a single cycle and outputs hold
        @(negedge clk);
        check("R2 done drops", int'(done), 0);
        for (int p = 0; p < 16; p++)
            check($sformatf("R2 hold p%0d", p), int'($signed(coef_out[p*16 +: 16])), expa[p]);

        // R7: zero block yields clean zero
        fill_all(0);
        run_one("R7 zero", 30, 1'b0, 1'b0);

        // R9: full-scale negative and positive
        fill_all(-32768);
        run_one("R9 neg full AC", 0, 1'b0, 1'b1);
        fill_all(32767);
        run_one("R9 pos full DC", 0, 1'b1, 1'b1);
        fill_all(-32768);
        run_one("R9 neg full qp51", 51, 1'b0, 1'b0);

        // R8: back-to-back blocks with different parameters
        make_ramp(1234, -321);
        compute(7, 1'b0, 1'b1, expa);
        @(negedge clk);
        drive(7, 1'b0, 1'b1);
        make_ramp(-4321, 555);
        compute(33, 1'b1, 1'b0, expb);
        @(negedge clk);
        drive(33, 1'b1, 1'b0);
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check_block("R8 first", expa);
        @(negedge clk);
        check_block("R8 second", expb);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule